// File: doc/BRIEF.md
# Keyed Independent Watchdog

This block is a watchdog timer that software services only by writing special key values. A slow, free-running clock from outside the main clock domain is brought in through a short synchronizer, and each of its rising edges becomes one tick. A selectable prescaler divides the ticks, and each prescaled step decrements a 12-bit down counter. If software fails to write the refresh key before the counter runs out, the block raises a reset request for one cycle and then returns to its power-on state.

Configuration lives behind a lock. Software first writes the unlock key. It then sets the divider code and the reload value. Writing the refresh key re-arms the lock, and the start key launches the counter. Once the counter is running, no write can halt it. A debug-freeze input holds the counter and the prescaler so that a halted processor does not trigger a spurious reset.

Top module: `keyed_wdog`

## Requirements
- R1: After the synchronous reset, rst_req_o is low, the watchdog is idle, the configuration is locked, the divider code is 0 and the reload value is 0xFFF. While idle, no tick produces a reset request.
- R2: A write of 0xCCCC to address 0 (key register) while idle starts the watchdog. The counter loads from the reload value and the prescaler phase is cleared.
- R3: A write of 0xAAAA to address 0 reloads the counter from the reload value and clears the prescaler phase, so a full timeout period begins again.
- R4: A write of 0x5555 to address 0 unlocks the configuration. While unlocked, address 1 takes the divider code from wr_data[2:0] and address 2 takes the reload value from wr_data[11:0]. While locked, writes to either address are ignored.
- R5: The refresh key 0xAAAA locks the configuration again.
- R6: Divider code p divides the tick count by 4·2^p for p from 0 to 6. Codes 6 and 7 both divide by 256.
- R7: Let R be the reload value. With no further refresh, the reset request fires after exactly max(R,1) prescaled steps, counted from the last start or refresh.
- R8: While dbg_halt_i is high, ticks are ignored, so neither the prescaler nor the counter advances.
- R9: Once the watchdog is running, only a timeout or the system reset stops it. Key writes of any value other than the three keys have no effect, and a second start key also has no effect.
- R10: rst_req_o is a pulse one clock cycle wide. In the same clock edge that raises it, the block returns to the state described in R1.
- R11: slow_clk_i passes through a two-stage synchronizer. Each rising edge of slow_clk_i counts as exactly one tick, however long the high phase lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 key, 1 divider code, 2 reload value |
| wr_data_i | input | 16 | Write data |
| slow_clk_i | input | 1 | Slow tick clock, asynchronous to clk |
| dbg_halt_i | input | 1 | Debug freeze |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The assertions check several properties on every cycle. The reset request is a single-cycle pulse, and the watchdog stops running only in the cycle that fires. Locked configuration writes leave the stored values unchanged, and the refresh key always re-arms the lock. A frozen counter holds its value, and every clear returns the prescaler phase to zero. Other properties depend on tick counts across long stretches of time, so only the bench scenarios can show them. These are the exact timeout length for each divider code and reload value, the restart of the timeout period on a refresh, the return to default configuration after a fire, and the rejection of other key values while running.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_REFILL = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_OPEN   = 16'h5555;

  localparam logic [1:0] ADDR_KEY  = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_LOAD = 2'd2;
endpackage

// File: rtl/kwd_tick_sync.sv
module kwd_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_i,
  output logic tick_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[STAGES-1:0], slow_i};
  end

  assign tick_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // R11: a tick is never followed directly by another tick
  a_r11_single_tick: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/kwd_cfg.sv
module kwd_cfg
  import kwd_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [KEY_W-1:0] wr_data_i,
  output logic             start_o,
  output logic             refill_o,
  output logic [PS_W-1:0]  div_code_o,
  output logic [CNT_W-1:0] load_val_o
);
  logic open_q;
  logic key_wr, open_k;

  assign key_wr   = wr_en_i && (wr_addr_i == ADDR_KEY);
  assign start_o  = key_wr && (wr_data_i == KEY_START);
  assign refill_o = key_wr && (wr_data_i == KEY_REFILL);
  assign open_k   = key_wr && (wr_data_i == KEY_OPEN);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      open_q     <= 1'b0;
      div_code_o <= '0;
      load_val_o <= '1;
    end else begin
      if (open_k)        open_q <= 1'b1;
      else if (refill_o) open_q <= 1'b0;
      if (open_q && wr_en_i && wr_addr_i == ADDR_DIV)
        div_code_o <= wr_data_i[PS_W-1:0];
      if (open_q && wr_en_i && wr_addr_i == ADDR_LOAD)
        load_val_o <= wr_data_i[CNT_W-1:0];
    end
  end

  a_r4_locked_load: assert property (@(posedge clk) disable iff (rst)
    (!open_q && wr_en_i && wr_addr_i == ADDR_LOAD && !clear_i) |=> $stable(load_val_o));
  a_r4_locked_div: assert property (@(posedge clk) disable iff (rst)
    (!open_q && wr_en_i && wr_addr_i == ADDR_DIV && !clear_i) |=> $stable(div_code_o));
  a_r5_relock: assert property (@(posedge clk) disable iff (rst)
    refill_o |=> !open_q);
endmodule

// File: rtl/kwd_prescale.sv
module kwd_prescale #(
  parameter int PS_W      = 3,
  parameter int BASE_LOG  = 2,
  parameter int MAX_SHIFT = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear_i,
  input  logic            hold_i,
  input  logic            tick_i,
  input  logic [PS_W-1:0] code_i,
  output logic            step_o
);
  localparam int CW = BASE_LOG + MAX_SHIFT;

  logic [PS_W-1:0] shift_sel;
  logic [CW-1:0]   limit, phase_q;
  logic            adv;

  assign shift_sel = (int'(code_i) > MAX_SHIFT) ? PS_W'(MAX_SHIFT) : code_i;
  assign limit     = CW'((1 << (BASE_LOG + int'(shift_sel))) - 1);
  assign adv       = tick_i && !hold_i;
  assign step_o    = adv && (phase_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || clear_i) phase_q <= '0;
    else if (step_o)    phase_q <= '0;
    else if (adv)       phase_q <= phase_q + 1'b1;
  end

  a_r3_phase_cleared: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (phase_q == '0));
  a_r8_phase_frozen: assert property (@(posedge clk) disable iff (rst)
    (hold_i && !clear_i) |=> $stable(phase_q));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int KEY_W       = 16,
  parameter int CNT_W       = 12,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [KEY_W-1:0] wr_data_i,
  input  logic             slow_clk_i,
  input  logic             dbg_halt_i,
  output logic             rst_req_o
);
  logic             tick, step, fire;
  logic             start_k, refill_k;
  logic [PS_W-1:0]  div_code;
  logic [CNT_W-1:0] load_val, cnt_q;
  logic             running_q;

  kwd_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .slow_i(slow_clk_i), .tick_o(tick));

  kwd_cfg #(.CNT_W(CNT_W), .PS_W(PS_W)) u_cfg (
    .clk(clk), .rst(rst), .clear_i(fire),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .start_o(start_k), .refill_o(refill_k),
    .div_code_o(div_code), .load_val_o(load_val));

  kwd_prescale #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst(rst),
    .clear_i(fire || refill_k || (start_k && !running_q)),
    .hold_i(dbg_halt_i || !running_q),
    .tick_i(tick), .code_i(div_code), .step_o(step));

  assign fire = running_q && step && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
      cnt_q     <= '1;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= fire;
      if (fire) begin
        running_q <= 1'b0;
        cnt_q     <= '1;
      end else if (start_k && !running_q) begin
        running_q <= 1'b1;
        cnt_q     <= load_val;
      end else if (refill_k) begin
        cnt_q <= load_val;
      end else if (running_q && step) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);
  a_r10_idle_after: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> !running_q);
  a_r9_no_stop: assert property (@(posedge clk) disable iff (rst)
    $fell(running_q) |-> rst_req_o);
  a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
    (running_q && dbg_halt_i && !refill_k) |=> $stable(cnt_q));
endmodule

// File: tb/keyed_wdog_tb_top.sv
`timescale 1ns/1ps
module keyed_wdog_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        slow_clk = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  keyed_wdog dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .slow_clk_i(slow_clk), .dbg_halt_i(dbg_halt),
    .rst_req_o(rst_req));

  always @(negedge clk) begin
    cycles++;
    if (rst_req) req_cnt++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int divisor(input int p);
    return 4 << ((p > 6) ? 6 : p);
  endfunction

  function automatic int timeout_ticks(input int p, input int r);
    return ((r < 1) ? 1 : r) * divisor(p);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      slow_clk = 1'b1;
      repeat (3) @(negedge clk);
      slow_clk = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic configure(input int p, input int r);
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'(p));
    wr(2'd2, 16'(r));
    wr(2'd0, 16'hAAAA);
  endtask

  // fires after exactly n further ticks, not one earlier
  task automatic expect_fire(input int n, input string tag);
    int base = req_cnt;
    pulses(n - 1);
    check(req_cnt == base, {tag, " early"}, req_cnt - base, 0);
    pulses(1);
    check(req_cnt == base + 1, {tag, " on time"}, req_cnt - base, 1);
  endtask

  initial begin
    int base;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: quiet after reset, idle ignores ticks
    check(rst_req == 1'b0, "R1 reset level", rst_req, 0);
    pulses(40);
    check(req_cnt == 0, "R1 idle no request", req_cnt, 0);

    // R2 R7 R1: start with defaults -> 4095*4 ticks
    wr(2'd0, 16'hCCCC);
    expect_fire(timeout_ticks(0, 4095), "R2 R7 default timeout");

    // R10: after the pulse the block is idle again
    base = req_cnt;
    pulses(300);
    check(req_cnt == base, "R10 idle after fire", req_cnt - base, 0);

    // R4 R5: locked writes ignored, relock after refresh
    wr(2'd2, 16'd9);
    wr(2'd1, 16'd3);
    configure(0, 3);
    wr(2'd2, 16'd20);
    wr(2'd1, 16'd2);
    wr(2'd0, 16'hCCCC);
    expect_fire(timeout_ticks(0, 3), "R4 R5 lock");

    // R10: defaults restored after fire -> p=0 r=4095; check by early stop
    wr(2'd0, 16'hCCCC);
    base = req_cnt;
    pulses(20);
    check(req_cnt == base, "R10 defaults restored", req_cnt - base, 0);
    configure(0, 2);
    expect_fire(timeout_ticks(0, 2), "R3 R10 refresh after defaults");

    // R9: bogus keys and second start do not stop or refresh
    configure(1, 4);
    wr(2'd0, 16'hCCCC);
    pulses(10);
    wr(2'd0, 16'h1234);
    wr(2'd0, 16'hCCCC);
    wr(2'd0, 16'h0000);
    expect_fire(timeout_ticks(1, 4) - 10, "R9 other keys");

    // R3: refresh restarts the period
    configure(0, 3);
    wr(2'd0, 16'hCCCC);
    pulses(10);
    wr(2'd0, 16'hAAAA);
    expect_fire(timeout_ticks(0, 3), "R3 refresh");

    // R6: codes 6 and 7 both divide by 256
    configure(6, 1);
    wr(2'd0, 16'hCCCC);
    expect_fire(256, "R6 code 6");
    configure(7, 1);
    wr(2'd0, 16'hCCCC);
    expect_fire(256, "R6 code 7");

    // R8: freeze holds counter and prescaler
    configure(0, 2);
    wr(2'd0, 16'hCCCC);
    pulses(3);
    dbg_halt = 1'b1;
    base = req_cnt;
    pulses(40);
    check(req_cnt == base, "R8 frozen", req_cnt - base, 0);
    dbg_halt = 1'b0;
    expect_fire(5, "R8 resume");

    // R7: reload value 0 behaves as 1
    configure(0, 0);
    wr(2'd0, 16'hCCCC);
    expect_fire(4, "R7 zero reload");

    // R11: a long high phase counts once
    configure(0, 1);
    wr(2'd0, 16'hCCCC);
    pulses(2);
    slow_clk = 1'b1;
    repeat (40) @(negedge clk);
    slow_clk = 1'b0;
    repeat (3) @(negedge clk);
    expect_fire(1, "R11 long high");

    // R6 R7: random configurations
    for (int k = 0; k < 8; k++) begin
      int p = int'($urandom % 4);
      int r = 1 + int'($urandom % 6);
      configure(p, r);
      wr(2'd0, 16'hCCCC);
      expect_fire(timeout_ticks(p, r), "R6 R7 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule